// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block steers the receive side of a network MAC through a list of buffer descriptors held in memory. Each descriptor is four 32-bit words at a fixed stride. The walker fetches a descriptor and checks that the DMA side owns it. It then offers the frame writer one or two buffers, each an address and a byte size. When a frame ends, or the descriptor has no room left, the walker writes a status word back to the descriptor. That status word hands ownership back to the CPU.

The walker finds the next descriptor in one of three ways: it follows a chain pointer, steps by the stride, or wraps to the list base. When it meets a descriptor still owned by the CPU, it parks with a suspend flag raised. It stays parked until software pulses resume, and then it fetches that same descriptor again. A start pulse, accepted in any state, loads a new list base and begins fetching from it.

Descriptor layout:
- Word 0: bit 31 is the ownership flag.
- Word 1: bits 12:0 hold the size of buffer 1 and bits 28:16 the size of buffer 2. Bit 14 is the chain bit and bit 15 is the end-of-ring bit.
- Word 2: the buffer 1 address.
- Word 3: the buffer 2 address, or the next-descriptor pointer when chained.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset the block is idle until a start pulse: rd_req, buf_valid, wb_req and suspended are all 0.
- R2: A fetch reads words 0, 1, 2 and 3 in turn at descriptor address +0, +4, +8 and +12. Each read holds rd_req and rd_addr steady until rd_ack. Bit 31 of word 0 set means the DMA side owns the descriptor.
- R3: If word 0 bit 31 is 0, the walker raises suspended and issues no read, buffer or write-back. It stays that way until resume, and then it fetches the same descriptor address again.
- R4: Buffer 1 is offered with the word 2 address and the size in word 1 bits 12:0. A size of 0 skips buffer 1.
- R5: When chain (word 1 bit 14) is 0 and the size in word 1 bits 28:16 is nonzero, buffer 2 is offered with the word 3 address. It comes after buffer 1 fills without a frame end, or first if buffer 1 was skipped.
- R6: When chain is 1, buffer 2 is never offered, and the next descriptor address is word 3.
- R7: When end-of-ring (word 1 bit 15) is 1, the next descriptor address is the list base, even if chain is also set.
- R8: With neither chain nor end-of-ring set, the next descriptor address is the current one plus 16.
- R9: The status is written to the descriptor's word 0 address when the frame writer signals a segment that is last, or when the offered buffers are used up. The status always has bit 31 at 0, and wb_req with wb_addr/wb_data is held until wb_ack.
- R10: In the status word, bits 29:16 hold the frame's running byte count and bit 9 marks that the descriptor holds the frame's first segment. Bit 8 marks that it holds the last segment. All other bits are 0.
- R11: A descriptor with no usable buffer is released at once with a status word of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor |
| start | input | 1 | Load ring_base and begin fetching |
| resume | input | 1 | Leave suspension and refetch |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the word read |
| rd_ack | input | 1 | Read accepted, rd_data valid |
| rd_data | input | 32 | Read data |
| buf_valid | output | 1 | A buffer is offered to the frame writer |
| buf_addr | output | 32 | Offered buffer address |
| buf_size | output | LEN_W | Offered buffer size in bytes |
| seg_done | input | 1 | Writer finished with the offered buffer |
| seg_bytes | input | LEN_W | Bytes written into that buffer |
| seg_last | input | 1 | That segment ended the frame |
| wb_req | output | 1 | Status write-back request |
| wb_addr | output | 32 | Write-back address (descriptor word 0) |
| wb_data | output | 32 | Status word |
| wb_ack | input | 1 | Write-back accepted |
| suspended | output | 1 | Parked on a CPU-owned descriptor |

## Verification
The bench builds the walker with its defaults: 13-bit size fields and a four-word descriptor stride. These match the bit positions in word 1, so every flag combination it stores is decoded as specified. Read acknowledges arrive only every other cycle, so the hold rules are exercised. A hand-built ring covers the following:
- a frame spread across descriptors;
- a skipped buffer 1;
- end-of-ring together with chain;
- a chained hop;
- an empty descriptor;
- two suspensions.

A sweep then moves the split between buffer 1 and buffer 2 across all eight cases of a 28-byte frame, from buffer 1 skipped to buffer 2 skipped. Each expected status is computed from the sizes.

// File: rtl/rx_ring_walker.sv
module rx_ring_walker #(
  parameter int LEN_W      = 13,
  parameter int DESC_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ring_base,
  input  logic             start,
  input  logic             resume,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_ack,
  input  logic [31:0]      rd_data,
  output logic             buf_valid,
  output logic [31:0]      buf_addr,
  output logic [LEN_W-1:0] buf_size,
  input  logic             seg_done,
  input  logic [LEN_W-1:0] seg_bytes,
  input  logic             seg_last,
  output logic             wb_req,
  output logic [31:0]      wb_addr,
  output logic [31:0]      wb_data,
  input  logic             wb_ack,
  output logic             suspended
);
  localparam int STRIDE = DESC_WORDS * 4;
  localparam int FL     = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DISP, S_BUF, S_WB, S_SUSP} st_t;

  st_t              st;
  logic [31:0]      base_q, desc_addr, b1, b2;
  logic [1:0]       widx;
  logic [LEN_W-1:0] sz1, sz2;
  logic             chain, eor, use_b2, used, first_q, last_q, open_q;
  logic [FL-1:0]    flen;

  wire        b2_ok     = !chain && (sz2 != '0);
  wire [31:0] next_addr = eor ? base_q : (chain ? b2 : desc_addr + 32'(STRIDE));

  assign rd_req    = (st == S_FETCH);
  assign rd_addr   = desc_addr + {28'd0, widx, 2'b00};
  assign buf_valid = (st == S_BUF);
  assign buf_addr  = use_b2 ? b2 : b1;
  assign buf_size  = use_b2 ? sz2 : sz1;
  assign wb_req    = (st == S_WB);
  assign wb_addr   = desc_addr;
  assign wb_data   = used ? ((32'(flen) << 16) | (32'(first_q) << 9) | (32'(last_q) << 8)) : 32'd0;
  assign suspended = (st == S_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  base_q <= '0;  desc_addr <= '0;  widx <= '0;
      sz1 <= '0;  sz2 <= '0;  chain <= 1'b0;  eor <= 1'b0;
      b1 <= '0;  b2 <= '0;  use_b2 <= 1'b0;  used <= 1'b0;
      first_q <= 1'b0;  last_q <= 1'b0;  open_q <= 1'b0;  flen <= '0;
    end else if (start) begin
      base_q <= ring_base;  desc_addr <= ring_base;  widx <= '0;
      open_q <= 1'b0;  flen <= '0;  st <= S_FETCH;
    end else begin
      case (st)
        S_FETCH: if (rd_ack) begin
          if (widx == 2'd0 && !rd_data[31]) st <= S_SUSP;
          else begin
            widx <= widx + 2'd1;
            case (widx)
              2'd1: begin
                sz1   <= rd_data[LEN_W-1:0];
                sz2   <= rd_data[16 +: LEN_W];
                chain <= rd_data[14];
                eor   <= rd_data[15];
              end
              2'd2: b1 <= rd_data;
              2'd3: begin b2 <= rd_data; st <= S_DISP; end
              default: ;
            endcase
          end
        end
        S_DISP: begin
          first_q <= !open_q;
          last_q  <= 1'b0;
          used    <= 1'b0;
          if (!open_q) flen <= '0;
          if (sz1 != '0) begin use_b2 <= 1'b0; st <= S_BUF; end
          else if (b2_ok) begin use_b2 <= 1'b1; st <= S_BUF; end
          else st <= S_WB;
        end
        S_BUF: if (seg_done) begin
          flen   <= flen + FL'(seg_bytes);
          used   <= 1'b1;
          open_q <= !seg_last;
          if (seg_last) begin last_q <= 1'b1; st <= S_WB; end
          else if (!use_b2 && b2_ok) use_b2 <= 1'b1;
          else st <= S_WB;
        end
        S_WB: if (wb_ack) begin desc_addr <= next_addr; st <= S_FETCH; end
        S_SUSP: if (resume) st <= S_FETCH;
        default: ;
      endcase
    end
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !start |=> rd_req && $stable(rd_addr));

  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack && !start |=> wb_req && $stable(wb_data) && $stable(wb_addr));

  // R9
  wb_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !wb_data[31]);

  // R3
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !rd_req && !buf_valid && !wb_req);

  // R3
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !resume && !start |=> suspended);

  // R4
  buf_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> buf_size != '0);

  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, buf_valid, wb_req, suspended}));
endmodule

// File: tb/rx_ring_walker_tb.sv
`timescale 1ns/1ps
module rx_ring_walker_tb;
  localparam int LW = 13;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 0, rst_n = 0, start = 0, resume = 0;
  logic [31:0] ring_base = 0;
  logic rd_req, rd_ack = 0, buf_valid, seg_done = 0, seg_last = 0;
  logic wb_req, wb_ack = 0, suspended;
  logic [31:0] rd_addr, rd_data = 0, buf_addr, wb_addr, wb_data;
  logic [LW-1:0] buf_size, seg_bytes = 0;

  logic [31:0] mem [128];
  logic [31:0] wa [16];
  logic [31:0] wd [16];
  int wb_n = 0;
  logic [31:0] last_w0 = 0;
  logic tog = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rx_ring_walker #(.LEN_W(LW), .DESC_WORDS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .start(start), .resume(resume),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_size(buf_size),
    .seg_done(seg_done), .seg_bytes(seg_bytes), .seg_last(seg_last),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
    .suspended(suspended));

  always @(negedge clk) begin
    tog     <= ~tog;
    rd_ack  <= rd_req & tog;
    rd_data <= mem[rd_addr[8:2]];
    wb_ack  <= wb_req;
  end

  always @(posedge clk) begin
    if (wb_req && wb_ack && wb_n < 16) begin
      wa[wb_n] <= wb_addr;
      wd[wb_n] <= wb_data;
      wb_n <= wb_n + 1;
    end
    if (rd_req && rd_ack && rd_addr[3:2] == 2'd0) last_w0 <= rd_addr;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_buf(input string tag);
    int t = 0;
    while (!buf_valid && t < 400) begin @(negedge clk); t++; end
    if (!buf_valid) check(0, {tag, " buffer offer"}, 0, 1);
  endtask

  task automatic seg(input logic [31:0] ea, input int es, input int nb, input bit last, input string tag);
    wait_buf(tag);
    check(buf_addr == ea, {tag, " buf_addr"}, buf_addr, ea);
    check(buf_size == LW'(es), {tag, " buf_size"}, 32'(buf_size), 32'(es));
    seg_done = 1; seg_bytes = LW'(nb); seg_last = last;
    @(negedge clk);
    seg_done = 0; seg_bytes = 0; seg_last = 0;
  endtask

  task automatic wait_wb(input int idx, input logic [31:0] ea, input logic [31:0] ed, input string tag);
    int t = 0;
    while (wb_n <= idx && t < 400) begin @(negedge clk); t++; end
    if (wb_n <= idx) check(0, {tag, " write-back missing"}, 32'(wb_n), 32'(idx + 1));
    else begin
      check(wa[idx] == ea, {tag, " wb_addr"}, wa[idx], ea);
      check(wd[idx] == ed, {tag, " wb_data"}, wd[idx], ed);
    end
  endtask

  task automatic wait_susp(input logic [31:0] ea, input string tag);
    int t = 0;
    while (!suspended && t < 400) begin @(negedge clk); t++; end
    check(suspended, {tag, " suspended"}, 32'(suspended), 1);
    check(last_w0 == ea, {tag, " fetch address"}, last_w0, ea);
  endtask

  task automatic pulse_start(input logic [31:0] b);
    ring_base = b; start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_resume();
    resume = 1; @(negedge clk); resume = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 0;
    mem[64] = OWN; mem[65] = (32'd32 << 16) | 32'd64;  mem[66] = 32'h1000; mem[67] = 32'h2000;
    mem[68] = OWN; mem[69] = (32'd48 << 16);           mem[70] = 32'h0;    mem[71] = 32'h3000;
    mem[72] = OWN; mem[73] = (32'd1 << 15) | (32'd1 << 14) | (32'd8 << 16) | 32'd16;
    mem[74] = 32'h4000; mem[75] = 32'h140;
    mem[80] = OWN; mem[81] = (32'd1 << 14) | (32'd12 << 16); mem[82] = 32'h5000; mem[83] = 32'h100;

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    check({rd_req, buf_valid, wb_req, suspended} == 4'b0, "R1 idle after reset",
          32'({rd_req, buf_valid, wb_req, suspended}), 0);

    pulse_start(32'h100);
    seg(32'h1000, 64, 64, 0, "R4 buffer 1");
    seg(32'h2000, 32, 20, 1, "R5 buffer 2");
    wait_wb(0, 32'h100, (32'd84 << 16) | 32'h300, "R10 whole frame in one descriptor");
    seg(32'h3000, 48, 48, 0, "R4 zero-size buffer 1 skipped, R5");
    wait_wb(1, 32'h110, (32'd48 << 16) | 32'h200, "R8 R9 exhaustion write-back");
    mem[64] = 0;
    seg(32'h4000, 16, 16, 1, "R6 chained buffer 2 not offered");
    wait_wb(2, 32'h120, (32'd64 << 16) | 32'h100, "R10 last segment");
    wait_susp(32'h100, "R7 end-of-ring over chain, R3");
    repeat (6) @(negedge clk);
    // R3
    check(suspended && !buf_valid && wb_n == 3, "R3 parked while CPU owns",
          32'(wb_n), 3);

    mem[65] = (32'd1 << 14) | 32'd32; mem[67] = 32'h140; mem[64] = OWN;
    pulse_resume();
    seg(32'h1000, 32, 8, 1, "R3 refetch after resume");
    wait_wb(3, 32'h100, (32'd8 << 16) | 32'h300, "R9 frame end");
    mem[64] = 0;
    wait_wb(4, 32'h140, 32'h0, "R6 chain pointer, R11 empty descriptor");
    wait_susp(32'h100, "R6 chain hop from empty descriptor");

    for (int k = 0; k < 8; k++) begin
      mem[97] = (32'd1 << 15) | (32'(4 * (7 - k)) << 16) | 32'(4 * k);
      mem[98] = 32'h6000 + 32'(k * 256);
      mem[99] = 32'h7000 + 32'(k * 256);
      mem[96] = OWN;
      if (k == 0) pulse_start(32'h180); else pulse_resume();
      wait_buf("R2 sweep fetch");
      mem[96] = 0;
      if (k > 0) seg(32'h6000 + 32'(k * 256), 4 * k, 4 * k, k == 7, "R4 sweep");
      if (k < 7) seg(32'h7000 + 32'(k * 256), 4 * (7 - k), 4 * (7 - k), 1, "R5 sweep");
      wait_wb(5 + k, 32'h180, (32'd28 << 16) | 32'h300, "R10 sweep status");
      wait_susp(32'h180, "R7 sweep wrap");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule